// File: doc/BRIEF.md
# Power-Fail Write-Protect Sequencer

This block supervises a battery-backed memory. Two digital flags arrive from analog comparators outside the block. The first, `vok_i`, says the supply is above the write-protect threshold. Its hysteresis is set outside the block, so a high level also means the supply is back in its full-function range. The second, `vbat_lvl_i`, says the supply is above the battery switchover level.

From these flags the block drives four outputs:

- a memory-access inhibit, which blocks every write and makes every access input a don't-care;
- a force that puts the data outputs in high impedance;
- a battery-connect select;
- a freshness latch.

The freshness latch keeps the backup battery isolated until the supply first comes up to a valid level. The latch is cleared only by a factory reset, so losing the supply or applying a chip reset does not clear it.

Protection is immediate: the inhibit follows a low supply flag with no clock edge in the path. Release is slow. The supply flag first passes through a synchronizer of `SYNC_STAGES` flops. It must then stay high for a further `RECOV_CYC` clock edges before access is allowed again. Any low sample during that wait restarts the whole count.

Top module: `pfail_guard`

## Requirements
- R1: While `vok_i` is low, `inhibit_o` and `hiz_o` are both high in the same cycle, with no clock edge needed.
- R2: After `vok_i` has been high for N consecutive rising edges, with `rst_ni` high throughout, `inhibit_o` goes low right after edge N, where N = SYNC_STAGES + RECOV_CYC. It stays high before that edge.
- R3: A single edge that samples `vok_i` low restarts the count of R2 from zero.
- R4: A factory reset (`factory_rst_ni` low) clears `armed_o`. `armed_o` is set by the first rising edge that samples `vok_i` high.
- R5: Once set, `armed_o` stays set through supply loss and through `rst_ni`. Only `factory_rst_ni` clears it.
- R6: `bat_sel_o` is high exactly when `armed_o` is high and `vbat_lvl_i` is low. While the block is unarmed, `bat_sel_o` stays low whatever the supply level.
- R7: While `rst_ni` is low, and after it is released, `inhibit_o` stays high until the full count of R2 has been completed again.
- R8: `hiz_o` equals `inhibit_o` at every point in time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the recovery timer and the latches |
| rst_ni | input | 1 | Active-low asynchronous reset of the synchronizer and the timer |
| factory_rst_ni | input | 1 | Active-low asynchronous clear of the freshness latch |
| vok_i | input | 1 | Supply is above the write-protect threshold |
| vbat_lvl_i | input | 1 | Supply is above the battery switchover level |
| inhibit_o | output | 1 | Blocks all memory accesses and writes |
| hiz_o | output | 1 | Forces the data outputs to high impedance |
| bat_sel_o | output | 1 | Connects the battery to the memory |
| armed_o | output | 1 | Freshness latch: battery backup is enabled |

## Verification
The bench drops `vok_i` for one cycle in the middle of a recovery wait. A design that only pauses its counter, or that lets a stale synchronizer stage finish the count, would release access too early. The release edge is checked at exactly SYNC_STAGES + RECOV_CYC edges, which catches off-by-one counters in either direction.

Chip resets and supply loss are applied after the block has been armed. A design that ties the freshness latch to `rst_ni` would drop `bat_sel_o` there, and so would a design whose latch follows the supply. The bench also lowers the supply while the block is unarmed, to catch a battery select that ignores the latch.

// File: rtl/pfg_pkg.sv
package pfg_pkg;
  typedef enum logic [1:0] {
    PH_DOWN = 2'd0,
    PH_HOLD = 2'd1,
    PH_RUN  = 2'd2
  } phase_e;
endpackage

// File: rtl/pfg_sync.sv
module pfg_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic all_hi_o
);
  logic [STAGES-1:0] st_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q[g] <= 1'b0;
        else         st_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q[g] <= 1'b0;
        else         st_q[g] <= st_q[g-1];
      end
    end
  end

  // every stage high: a low sample anywhere in the chain counts as a drop
  assign all_hi_o = &st_q;
endmodule

// File: rtl/pfg_recov_timer.sv
module pfg_recov_timer
  import pfg_pkg::*;
#(
  parameter int unsigned RECOV_CYC = 1000000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ok_i,
  output logic ready_o
);
  localparam int unsigned CW = $clog2(RECOV_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(RECOV_CYC - 1);

  phase_e        phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    if (!ok_i) begin
      phase_d = PH_DOWN;
      cnt_d   = '0;
    end else if (phase_q != PH_RUN) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LAST) phase_d = PH_RUN;
      else               phase_d = PH_HOLD;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_DOWN;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  // gate with the live chain so a fresh drop cannot leave a stale release
  assign ready_o = (phase_q == PH_RUN) && ok_i;
endmodule

// File: rtl/pfg_seal.sv
module pfg_seal (
  input  logic clk_i,
  input  logic factory_rst_ni,
  input  logic vok_i,
  output logic armed_o
);
  logic armed_q;

  always_ff @(posedge clk_i or negedge factory_rst_ni) begin
    if (!factory_rst_ni) armed_q <= 1'b0;
    else if (vok_i)      armed_q <= 1'b1;
  end

  assign armed_o = armed_q;
endmodule

// File: rtl/pfail_guard.sv
module pfail_guard #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RECOV_CYC   = 1000000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic factory_rst_ni,
  input  logic vok_i,
  input  logic vbat_lvl_i,
  output logic inhibit_o,
  output logic hiz_o,
  output logic bat_sel_o,
  output logic armed_o
);
  logic ok_sync, ready, armed;

  pfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .d_i     (vok_i),
    .all_hi_o(ok_sync)
  );

  pfg_recov_timer #(.RECOV_CYC(RECOV_CYC)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ok_i   (ok_sync),
    .ready_o(ready)
  );

  pfg_seal u_seal (
    .clk_i         (clk_i),
    .factory_rst_ni(factory_rst_ni),
    .vok_i         (vok_i),
    .armed_o       (armed)
  );

  // raw flag in the path: protection never waits for an edge
  assign inhibit_o = ~vok_i | ~ready;
  assign hiz_o     = ~vok_i | ~ready;
  assign bat_sel_o = armed & ~vbat_lvl_i;
  assign armed_o   = armed;
endmodule

// File: rtl/pfail_guard_chk.sv
module pfail_guard_chk #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RECOV_CYC   = 1000000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic factory_rst_ni,
  input logic vok_i,
  input logic vbat_lvl_i,
  input logic inhibit_o,
  input logic hiz_o,
  input logic bat_sel_o,
  input logic armed_o
);
  localparam int unsigned LIM = SYNC_STAGES + RECOV_CYC;

  int unsigned run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          run_q <= 0;
    else if (!vok_i)      run_q <= 0;
    else if (run_q < LIM) run_q <= run_q + 1;
  end

  AST_LOW_INHIBIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vok_i |-> (inhibit_o && hiz_o)); // R1

  AST_RELEASE_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inhibit_o |-> (run_q >= LIM)); // R2

  AST_RELEASE_AFTER_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(inhibit_o) |-> $past(vok_i)); // R3

  AST_ARM_ON_SUPPLY: assert property (@(posedge clk_i) disable iff (!factory_rst_ni)
    $rose(armed_o) |-> $past(vok_i)); // R4

  AST_ARM_STICKY: assert property (@(posedge clk_i) disable iff (!factory_rst_ni)
    armed_o |=> armed_o); // R5

  AST_BAT_NEEDS_ARM: assert property (@(posedge clk_i) disable iff (!factory_rst_ni)
    bat_sel_o |-> (armed_o && !vbat_lvl_i)); // R6
endmodule

bind pfail_guard pfail_guard_chk #(
  .SYNC_STAGES(SYNC_STAGES),
  .RECOV_CYC  (RECOV_CYC)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .factory_rst_ni(factory_rst_ni),
  .vok_i         (vok_i),
  .vbat_lvl_i    (vbat_lvl_i),
  .inhibit_o     (inhibit_o),
  .hiz_o         (hiz_o),
  .bat_sel_o     (bat_sel_o),
  .armed_o       (armed_o)
);

// File: tb/pfail_guard_tb_top.sv
`timescale 1ns/1ps
module pfail_guard_tb_top;
  localparam int unsigned S = 2;
  localparam int unsigned R = 12;
  localparam int unsigned N = S + R;

  logic clk = 1'b0;
  logic rst_n, fac_n, vok, vbat;
  logic inh, hiz, bat, armed;

  int total = 0;
  int bad   = 0;
  int n_run = 0;
  bit m_armed = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pfail_guard #(.SYNC_STAGES(S), .RECOV_CYC(R)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .factory_rst_ni(fac_n),
    .vok_i(vok), .vbat_lvl_i(vbat),
    .inhibit_o(inh), .hiz_o(hiz), .bat_sel_o(bat), .armed_o(armed)
  );

  task automatic check(input string tag);
    bit e_inh, e_bat;
    e_inh = !vok || !rst_n || (n_run < N);
    e_bat = m_armed && !vbat;
    total++;
    if (inh !== e_inh || hiz !== e_inh || bat !== e_bat || armed !== m_armed) begin
      bad++;
      $display("FAIL %s: inh=%b hiz=%b bat=%b armed=%b exp inh=%b hiz=%b bat=%b armed=%b",
               tag, inh, hiz, bat, armed, e_inh, e_inh, e_bat, m_armed);
    end
  endtask

  // drive at negedge, compare, then advance the model on the edge
  task automatic step(input bit v, input bit b, input bit rn, input bit fn, input string tag);
    @(negedge clk);
    vok = v; vbat = b; rst_n = rn; fac_n = fn;
    if (!fn) m_armed = 1'b0;
    if (!rn) n_run = 0;
    #1;
    check(tag);
    @(posedge clk);
    if (!rn)    n_run = 0;
    else if (v) n_run = n_run + 1;
    else        n_run = 0;
    if (fn && v) m_armed = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; fac_n = 1'b0; vok = 1'b0; vbat = 1'b0;
    step(0, 0, 0, 0, "R4 reset");
    step(1, 1, 0, 0, "R7 reset");
    for (int i = 0; i < 4; i++) step(0, 0, 1, 1, "R6 unarmed");
    for (int i = 0; i < N + 3; i++) step(1, 1, 1, 1, "R2 recovery");
    step(1, 1, 1, 1, "R4 armed");
    step(0, 1, 1, 1, "R1 sag");
    for (int i = 0; i < N - 2; i++) step(1, 1, 1, 1, "R3 partial");
    step(0, 1, 1, 1, "R3 glitch");
    for (int i = 0; i < N + 2; i++) step(1, 1, 1, 1, "R3 restart");
    for (int i = 0; i < 3; i++) step(0, 1, 1, 1, "R1 low");
    for (int i = 0; i < 3; i++) step(0, 0, 1, 1, "R6 battery");
    step(0, 1, 1, 1, "R5 supply loss");
    for (int i = 0; i < N + 2; i++) step(1, 1, 1, 1, "R8 track");
    step(1, 1, 0, 1, "R7 chip reset");
    step(1, 0, 0, 1, "R5 chip reset");
    for (int i = 0; i < N + 2; i++) step(1, 1, 1, 1, "R7 rerun");
    step(0, 0, 1, 0, "R4 factory clear");
    for (int i = 0; i < 3; i++) step(0, 0, 1, 1, "R6 resealed");
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: expired, exp completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule